// File: doc/BRIEF.md
# SPI Status and Configuration-Error Register

This block is the read-only status word of an SPI controller. It gathers the transmit and receive buffer state, a mode-fault flag, a slave-selected indication and four configuration-legality error flags into one 32-bit word that the register bus reads. Writes from the bus do not reach it; the word has no write path.

The buffer flags work in two ways. With FIFOs present, or whenever the controller runs in dual or quad lane mode, they mirror the full and empty indications of the transmit and receive FIFOs. Without FIFOs, in standard single-lane mode, they track a single transmit register and a single receive register, set and cleared by bus accesses and by transfer completion. The mode-fault flag records a slave-select assertion seen while the controller is master. A read of the status word clears it, and a one-clock interrupt strobe marks each rising edge. The configuration error flags are combinational checks of the current settings, registered once per clock and not held.

Top module: `spi_stat_reg`

## Requirements
- R1: After reset the word reads 0x000000A5: receive empty (bit 0), transmit empty (bit 2), slave selected (bit 5) and slave-mode error (bit 7) are 1. Every other bit is 0. Bits 31:10 always read 0, and bit 10 (command error) has no error source in this block.
- R2: The effective FIFO mode is `fifoMode` high or `laneMode` nonzero. Lane encoding is 00 single, 01 dual, and 10 or 11 quad. In that mode, one cycle after the inputs, bit 0 equals `rxFifoEmpty`, bit 1 `rxFifoFull`, bit 2 `txFifoEmpty` and bit 3 `txFifoFull`.
- R3: Outside FIFO mode, `txWrite` sets transmit full (bit 3) and clears transmit empty (bit 2) on the next clock. `xferDone` does the opposite. When both occur in the same cycle, the write wins.
- R4: Outside FIFO mode, `xferDone` sets receive full (bit 1) and clears receive empty (bit 0), and `rxRead` does the opposite. When both occur in the same cycle, the transfer wins. The two bits are always complements.
- R5: Active-low `ssN` passes through a two-flop synchronizer. Mode fault (bit 4) is set one clock after the synchronized select goes from inactive to active while `masterSel` is 1, which is three clocks after `ssN` falls.
- R6: A cycle with `statRead` high clears mode fault on the next clock. A set event in the same cycle wins, and the flag stays 1.
- R7: `modfIrq` is high for exactly the one cycle in which mode fault first reads 1 after reading 0.
- R8: Slave selected (bit 5) is 1 one clock after the synchronized select is active while `masterSel` is 0. Otherwise it is 0.
- R9: One clock after the configuration is applied: bit 9 is `loopEn` with a nonzero lane mode; bit 8 is `lsbFirst` with a nonzero lane mode; bit 7 is `masterSel`=0 with a nonzero lane mode; bit 6 is `clkPol`≠`clkPha` with a nonzero lane mode. None of these bits is sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | FIFOs present for single-lane mode |
| laneMode | input | 2 | 00 single, 01 dual, 1x quad |
| masterSel | input | 1 | 1 master, 0 slave |
| loopEn | input | 1 | Loopback enabled |
| lsbFirst | input | 1 | LSB-first bit order |
| clkPol | input | 1 | Clock polarity setting |
| clkPha | input | 1 | Clock phase setting |
| ssN | input | 1 | Asynchronous active-low slave select |
| txWrite | input | 1 | Bus write to the transmit register |
| rxRead | input | 1 | Bus read of the receive register |
| xferDone | input | 1 | SPI transfer completed |
| statRead | input | 1 | Bus read of this status word |
| txFifoFull | input | 1 | Transmit FIFO full |
| txFifoEmpty | input | 1 | Transmit FIFO empty |
| rxFifoFull | input | 1 | Receive FIFO full |
| rxFifoEmpty | input | 1 | Receive FIFO empty |
| statusWord | output | 32 | Status word |
| modfIrq | output | 1 | One-clock mode-fault interrupt |

## Verification
Two pairs of events can land in the same cycle. A status read can arrive in the cycle where a new mode fault is detected. A transmit write or receive read can arrive in the cycle of a transfer completion. A directed case holds `statRead` high across the slave-select edge while master, and expects bit 4 and the interrupt to rise anyway and bit 4 to clear one read later. Random stimulus makes both kinds of collision often, and each cycle it compares the word against a bench model that applies the stated priorities.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W = 32;
  localparam int FLAG_W = 11;

  typedef struct packed {
    logic fifoEff;
    logic txLoad;
    logic txDrain;
    logic rxFill;
    logic rxTake;
    logic modfSet;
    logic modfClr;
    logic slaveSel;
  } stat_strb_t;

  typedef struct packed {
    logic loopErr;
    logic orderErr;
    logic slaveErr;
    logic clockErr;
  } cfg_err_t;
endpackage

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoMode,
  input  logic [1:0] laneMode,
  input  logic       masterSel,
  input  logic       loopEn,
  input  logic       lsbFirst,
  input  logic       clkPol,
  input  logic       clkPha,
  input  logic       ssN,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       xferDone,
  input  logic       statRead,
  output stat_strb_t strb,
  output cfg_err_t   cfgErr
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncQ;
  logic ssSync;
  logic ssPrev;
  logic multiLane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      ssPrev <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_MSB-1:0], ~ssN};
      ssPrev <= ssSync;
    end
  end

  assign ssSync    = syncQ[SYNC_MSB];
  assign multiLane = (laneMode != 2'b00);

  always_comb begin
    strb.fifoEff  = fifoMode | multiLane;
    strb.txLoad   = txWrite;
    strb.txDrain  = xferDone;
    strb.rxFill   = xferDone;
    strb.rxTake   = rxRead;
    strb.modfSet  = ssSync & ~ssPrev & masterSel;
    strb.modfClr  = statRead;
    strb.slaveSel = ssSync & ~masterSel;
  end

  always_comb begin
    cfgErr.loopErr  = loopEn & multiLane;
    cfgErr.orderErr = lsbFirst & multiLane;
    cfgErr.slaveErr = ~masterSel & multiLane;
    cfgErr.clockErr = (clkPol ^ clkPha) & multiLane;
  end

  // R5: a new fault needs the synchronized select to have been inactive one cycle earlier
  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    strb.modfSet |=> !strb.modfSet);
endmodule

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stat_strb_t       strb,
  input  cfg_err_t         cfgErr,
  input  logic             txFifoFull,
  input  logic             txFifoEmpty,
  input  logic             rxFifoFull,
  input  logic             rxFifoEmpty,
  output logic [STAT_W-1:0] statusWord,
  output logic             modfIrq
);
  localparam int PAD_W = STAT_W - FLAG_W;

  logic       fifoEffQ;
  logic [3:0] fifoQ;     // {txFull, txEmpty, rxFull, rxEmpty}
  logic       txFullQ;
  logic       rxFullQ;
  logic       modfQ;
  logic       modfLastQ;
  logic       slaveSelQ;
  cfg_err_t   errQ;
  logic [3:0] bufBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEffQ  <= 1'b0;
      fifoQ     <= 4'b0101;
      txFullQ   <= 1'b0;
      rxFullQ   <= 1'b0;
      modfQ     <= 1'b0;
      modfLastQ <= 1'b0;
      slaveSelQ <= 1'b1;
      errQ      <= '{loopErr: 1'b0, orderErr: 1'b0, slaveErr: 1'b1, clockErr: 1'b0};
    end else begin
      fifoEffQ  <= strb.fifoEff;
      fifoQ     <= {txFifoFull, txFifoEmpty, rxFifoFull, rxFifoEmpty};
      if (strb.txLoad)       txFullQ <= 1'b1;
      else if (strb.txDrain) txFullQ <= 1'b0;
      if (strb.rxFill)       rxFullQ <= 1'b1;
      else if (strb.rxTake)  rxFullQ <= 1'b0;
      if (strb.modfSet)      modfQ <= 1'b1;
      else if (strb.modfClr) modfQ <= 1'b0;
      modfLastQ <= modfQ;
      slaveSelQ <= strb.slaveSel;
      errQ      <= cfgErr;
    end
  end

  assign bufBits    = fifoEffQ ? fifoQ : {txFullQ, ~txFullQ, rxFullQ, ~rxFullQ};
  assign modfIrq    = modfQ & ~modfLastQ;
  assign statusWord = {{PAD_W{1'b0}}, 1'b0, errQ.loopErr, errQ.orderErr, errQ.slaveErr,
                       errQ.clockErr, slaveSelQ, modfQ, bufBits};

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.modfSet |=> modfQ);
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modfClr && !strb.modfSet) |=> !modfQ);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    modfIrq |=> !modfIrq);
  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> txFullQ);
  a_r4_done_fills: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxFill |=> rxFullQ);
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic [1:0]        laneMode,
  input  logic              masterSel,
  input  logic              loopEn,
  input  logic              lsbFirst,
  input  logic              clkPol,
  input  logic              clkPha,
  input  logic              ssN,
  input  logic              txWrite,
  input  logic              rxRead,
  input  logic              xferDone,
  input  logic              statRead,
  input  logic              txFifoFull,
  input  logic              txFifoEmpty,
  input  logic              rxFifoFull,
  input  logic              rxFifoEmpty,
  output logic [STAT_W-1:0] statusWord,
  output logic              modfIrq
);
  stat_strb_t strb;
  cfg_err_t   cfgErr;

  spi_stat_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .laneMode(laneMode),
    .masterSel(masterSel), .loopEn(loopEn), .lsbFirst(lsbFirst),
    .clkPol(clkPol), .clkPha(clkPha), .ssN(ssN), .txWrite(txWrite),
    .rxRead(rxRead), .xferDone(xferDone), .statRead(statRead),
    .strb(strb), .cfgErr(cfgErr)
  );

  spi_stat_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgErr(cfgErr),
    .txFifoFull(txFifoFull), .txFifoEmpty(txFifoEmpty),
    .rxFifoFull(rxFifoFull), .rxFifoEmpty(rxFifoEmpty),
    .statusWord(statusWord), .modfIrq(modfIrq)
  );

  a_r9_loop_err: assert property (@(posedge clk) disable iff (!rstN)
    (loopEn && laneMode != 2'b00) |=> statusWord[9]);
  a_r2_lane_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (laneMode != 2'b00) |=> (statusWord[0] == $past(rxFifoEmpty)));
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:10] == '0);
endmodule

// File: tb/test_spi_stat_reg.sv
module test_spi_stat_reg;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoMode = 0, masterSel = 1, loopEn = 0, lsbFirst = 0, clkPol = 0, clkPha = 0;
  logic [1:0] laneMode = 2'b00;
  logic ssN = 1, txWrite = 0, rxRead = 0, xferDone = 0, statRead = 0;
  logic txFifoFull = 0, txFifoEmpty = 1, rxFifoFull = 0, rxFifoEmpty = 1;
  logic [31:0] statusWord;
  logic modfIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  spi_stat_reg i_spi_stat_reg (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .laneMode(laneMode),
    .masterSel(masterSel), .loopEn(loopEn), .lsbFirst(lsbFirst),
    .clkPol(clkPol), .clkPha(clkPha), .ssN(ssN), .txWrite(txWrite),
    .rxRead(rxRead), .xferDone(xferDone), .statRead(statRead),
    .txFifoFull(txFifoFull), .txFifoEmpty(txFifoEmpty),
    .rxFifoFull(rxFifoFull), .rxFifoEmpty(rxFifoEmpty),
    .statusWord(statusWord), .modfIrq(modfIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the requirements
  logic mS1, mS2, mSp, mModf, mModfL, mSlv, mTxF, mRxF, mFifo;
  logic [3:0] mFq, mErr;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mSp <= 0; mModf <= 0; mModfL <= 0; mSlv <= 1;
      mTxF <= 0; mRxF <= 0; mFifo <= 0; mFq <= 4'b0101; mErr <= 4'b0010;
    end else begin
      mS1 <= ~ssN; mS2 <= mS1; mSp <= mS2;
      mModf <= (mS2 && !mSp && masterSel) ? 1'b1 : (statRead ? 1'b0 : mModf);
      mModfL <= mModf;
      mSlv <= mS2 && !masterSel;
      mTxF <= txWrite ? 1'b1 : (xferDone ? 1'b0 : mTxF);
      mRxF <= xferDone ? 1'b1 : (rxRead ? 1'b0 : mRxF);
      mFifo <= fifoMode || laneMode != 0;
      mFq <= {txFifoFull, txFifoEmpty, rxFifoFull, rxFifoEmpty};
      mErr <= {loopEn && laneMode != 0, lsbFirst && laneMode != 0,
               !masterSel && laneMode != 0, (clkPol != clkPha) && laneMode != 0};
    end
  end

  function automatic logic [31:0] expWord();
    logic [3:0] b;
    b = mFifo ? mFq : {mTxF, !mTxF, mRxF, !mRxF};
    return {22'd0, mErr, mSlv, mModf, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] e;
    e = expWord();
    if (mFifo) chk("R2 buffer bits", {28'd0, statusWord[3:0]}, {28'd0, e[3:0]});
    else begin
      chk("R3 tx bits", {30'd0, statusWord[3:2]}, {30'd0, e[3:2]});
      chk("R4 rx bits", {30'd0, statusWord[1:0]}, {30'd0, e[1:0]});
    end
    chk("R5 R6 mode fault", {31'd0, statusWord[4]}, {31'd0, e[4]});
    chk("R8 slave selected", {31'd0, statusWord[5]}, {31'd0, e[5]});
    chk("R9 config errors", {28'd0, statusWord[9:6]}, {28'd0, e[9:6]});
    chk("R1 upper bits", {22'd0, statusWord[31:10]}, 32'd0);
    chk("R7 interrupt", {31'd0, modfIrq}, {31'd0, mModf && !mModfL});
  endtask

  task automatic idleInputs();
    txWrite = 0; rxRead = 0; xferDone = 0; statRead = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset value
    chk("R1 reset word", statusWord, 32'h0000_00A5);
    chk("R1 reset irq", {31'd0, modfIrq}, 32'd0);
    rstN = 1;
    @(negedge clk);
    compareAll();

    // R3 tie: write and transfer done together, write wins
    txWrite = 1; xferDone = 1;
    @(negedge clk); idleInputs();
    chk("R3 write wins tie", {28'd0, statusWord[3:0]}, 32'h0000_000A);
    // R4 tie: done and rx read together, done wins
    rxRead = 1; xferDone = 1;
    @(negedge clk); idleInputs();
    chk("R4 done wins tie", {28'd0, statusWord[3:0]}, 32'h0000_0006);

    // R6/R7 collision: read held across the select edge while master
    masterSel = 1; statRead = 1; ssN = 0;
    @(negedge clk); @(negedge clk);
    chk("R5 not yet set", {31'd0, statusWord[4]}, 32'd0);
    @(negedge clk);
    chk("R6 set beats read", {31'd0, statusWord[4]}, 32'd1);
    chk("R7 irq on rise", {31'd0, modfIrq}, 32'd1);
    @(negedge clk);
    chk("R6 read clears", {31'd0, statusWord[4]}, 32'd0);
    chk("R7 irq one cycle", {31'd0, modfIrq}, 32'd0);
    statRead = 0; ssN = 1;
    repeat (3) @(negedge clk);

    // R9 directed: quad, slave, loopback, lsb-first, mode 01
    laneMode = 2'b10; masterSel = 0; loopEn = 1; lsbFirst = 1; clkPol = 0; clkPha = 1;
    @(negedge clk);
    chk("R9 all errors", {28'd0, statusWord[9:6]}, 32'h0000_000F);
    laneMode = 2'b00;
    @(negedge clk);
    chk("R9 not sticky", {28'd0, statusWord[9:6]}, 32'h0000_0000);
    masterSel = 1; loopEn = 0; lsbFirst = 0; clkPha = 0;
    @(negedge clk);

    // random phase, model compared every cycle
    for (int n = 0; n < RAND_CYCLES; n++) begin
      compareAll();
      txWrite  = ($urandom % 4) == 0;
      rxRead   = ($urandom % 4) == 0;
      xferDone = ($urandom % 4) == 0;
      statRead = ($urandom % 4) == 0;
      if (($urandom % 6) == 0) ssN = ~ssN;
      if (($urandom % 40) == 0) masterSel = ~masterSel;
      if (($urandom % 60) == 0) laneMode = 2'($urandom);
      if (($urandom % 60) == 0) fifoMode = ~fifoMode;
      if (($urandom % 30) == 0) begin
        loopEn = 1'($urandom); lsbFirst = 1'($urandom);
        clkPol = 1'($urandom); clkPha = 1'($urandom);
      end
      {txFifoFull, txFifoEmpty, rxFifoFull, rxFifoEmpty} = 4'($urandom);
      @(negedge clk);
    end
    compareAll();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule